// File: doc/BRIEF.md
# One-Time-Programmable Fuse Controller

This block sits between a simple register bus and a one-time-programmable fuse array. Software selects a fuse word through a control register, supplies a 16-bit unlock key in the upper half of that register, and then writes the value to burn into a data register. The controller runs a request/acknowledge handshake with the fuse array, keeps a busy flag raised through the programming step and a fixed quiet interval afterwards, and raises a sticky error flag when a command is refused or the array reports a failure.

Every fuse word has a readable shadow copy. Shadows change only when software requests a shadow reload, which walks the whole array in ascending word order and copies each word into its shadow. The control register has two alias addresses: writing one sets the written bits, writing the other clears them. A timing word for the separate strobe-timing block is held in a register and driven out unchanged.

Top module: `otp_fuse_ctrl`

## Requirements
- R1: After reset the control register, the timing register and every shadow read as zero and no fuse request is raised.
- R2: The control register at offset 0x000 holds the word select in bits 7:0 and the unlock field in bits 31:16; a write to 0x000 loads both fields, a write to 0x004 ORs the written bits into them, and a write to 0x008 clears the written bits in them.
- R3: The timing register at offset 0x010 reads back the last value written and drives the timingCfg output.
- R4: A write to the data register at offset 0x020 while idle, with the unlock field equal to 0x3E77 and an in-range word select, issues one program request with fuseProg high, fuseIdx equal to the select and fuseWdata equal to the written value; busy (control bit 8) is high meanwhile.
- R5: A data write with any other unlock value issues no request and sets the error flag (control bit 9); the unlock field reads zero after every data write.
- R6: A data write whose word select is not below NUM_WORDS issues no request and sets the error flag.
- R7: After the array acknowledges a program request, busy stays high for exactly QUIET_CYCLES more clock cycles, so busy is high for the array latency plus QUIET_CYCLES cycles.
- R8: A data write, or a reload request, made while busy is ignored and sets the error flag.
- R9: Writing 1 to control bit 10 through 0x000 or 0x004 while idle reloads every shadow from the array in ascending word order; bit 10 and busy read 1 until the last word is copied, and shadows are otherwise unchanged, including by programming.
- R10: Shadow word i reads at offset 0x400 + 16*i; offsets in that window that are not 16-aligned or lie beyond the last word read zero.
- R11: An acknowledge with fuseErr high sets the error flag; the flag stays set until a write to 0x008 with bit 9 set, and a write to 0x000 does not clear it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWe | input | 1 | Register write strobe |
| busAddr | input | BUS_AW | Register byte offset |
| busWdata | input | 32 | Register write data |
| busRdata | output | 32 | Register read data (combinational) |
| fuseReq | output | 1 | Request to fuse array, held until acknowledged |
| fuseProg | output | 1 | 1 = program, 0 = read |
| fuseIdx | output | 8 | Fuse word index |
| fuseWdata | output | 32 | Value to program |
| fuseAck | input | 1 | One-cycle acknowledge from the array |
| fuseErr | input | 1 | Failure flag, valid with fuseAck |
| fuseRdata | input | 32 | Read data, valid with fuseAck |
| timingCfg | output | 32 | Timing word for the strobe-timing block |

## Verification
A controller stuck in or wrongly leaving its quiet state shows up as a busy count that differs from latency plus QUIET_CYCLES on the very next program. A reload index that skips or repeats a word is caught by the array model's order check during the reload and by shadow compare right after it. A lost or spurious unlock or error state becomes visible at the next control-register read, one cycle after the write that caused it.

// File: rtl/otp_fuse_pkg.sv
package otp_fuse_pkg;
  localparam int DW          = 32;
  localparam int SEL_W       = 8;
  localparam int KEY_W       = 16;
  localparam logic [KEY_W-1:0] UNLOCK_KEY = 16'h3E77;

  localparam int OFS_CTRL    = 'h000;
  localparam int OFS_SET     = 'h004;
  localparam int OFS_CLR     = 'h008;
  localparam int OFS_TIMING  = 'h010;
  localparam int OFS_DATA    = 'h020;
  localparam int OFS_SHADOW  = 'h400;

  localparam int BIT_BUSY    = 8;
  localparam int BIT_ERR     = 9;
  localparam int BIT_RELOAD  = 10;

  typedef struct packed {
    logic             progReq;
    logic             reloadReq;
    logic             keyOk;
    logic             idxOk;
    logic [SEL_W-1:0] idx;
  } reqEvt_t;

  typedef struct packed {
    logic             busy;
    logic             reloading;
    logic             setErr;
    logic             shadowWe;
    logic [SEL_W-1:0] shadowIdx;
  } ctrlStrb_t;

  typedef enum logic [1:0] {ST_IDLE, ST_PROG, ST_QUIET, ST_RELOAD} ctlState_e;
endpackage

// File: rtl/otp_reg_dp.sv
module otp_reg_dp
  import otp_fuse_pkg::*;
#(
  parameter int NUM_WORDS = 32,
  parameter int BUS_AW    = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWe,
  input  logic [BUS_AW-1:0] busAddr,
  input  logic [DW-1:0]     busWdata,
  output logic [DW-1:0]     busRdata,
  input  ctrlStrb_t         strb,
  input  logic [DW-1:0]     fuseRdata,
  output reqEvt_t           evt,
  output logic [DW-1:0]     progData,
  output logic [DW-1:0]     timingCfg
);
  localparam int IDXW = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;

  logic [SEL_W-1:0] selQ;
  logic [KEY_W-1:0] keyQ;
  logic             errQ;
  logic [DW-1:0]    timingQ;
  logic [DW-1:0]    dataQ;
  logic [DW-1:0]    shadowWord [NUM_WORDS];

  logic wrCtrl, wrSet, wrClr, wrTim, wrData;
  assign wrCtrl = busWe && (busAddr == BUS_AW'(OFS_CTRL));
  assign wrSet  = busWe && (busAddr == BUS_AW'(OFS_SET));
  assign wrClr  = busWe && (busAddr == BUS_AW'(OFS_CLR));
  assign wrTim  = busWe && (busAddr == BUS_AW'(OFS_TIMING));
  assign wrData = busWe && (busAddr == BUS_AW'(OFS_DATA));

  assign evt.progReq   = wrData;
  assign evt.reloadReq = (wrCtrl || wrSet) && busWdata[BIT_RELOAD];
  assign evt.keyOk     = (keyQ == UNLOCK_KEY);
  assign evt.idxOk     = (int'(selQ) < NUM_WORDS);
  assign evt.idx       = selQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      selQ    <= '0;
      keyQ    <= '0;
      errQ    <= 1'b0;
      timingQ <= '0;
      dataQ   <= '0;
    end else begin
      if (wrCtrl) begin
        selQ <= busWdata[SEL_W-1:0];
        keyQ <= busWdata[DW-1 -: KEY_W];
      end else if (wrSet) begin
        selQ <= selQ | busWdata[SEL_W-1:0];
        keyQ <= keyQ | busWdata[DW-1 -: KEY_W];
      end else if (wrClr) begin
        selQ <= selQ & ~busWdata[SEL_W-1:0];
        keyQ <= keyQ & ~busWdata[DW-1 -: KEY_W];
      end else if (wrData) begin
        keyQ <= '0;
      end
      if (strb.setErr) errQ <= 1'b1;
      else if (wrClr && busWdata[BIT_ERR]) errQ <= 1'b0;
      if (wrTim) timingQ <= busWdata;
      if (wrData && !strb.busy) dataQ <= busWdata;
    end
  end

  for (genvar gi = 0; gi < NUM_WORDS; gi++) begin : g_shadow
    logic [DW-1:0] wordQ;
    always_ff @(posedge clk) begin
      if (!rstN) wordQ <= '0;
      else if (strb.shadowWe && strb.shadowIdx == SEL_W'(gi)) wordQ <= fuseRdata;
    end
    assign shadowWord[gi] = wordQ;
  end

  logic [BUS_AW-1:0] shOff;
  logic [BUS_AW-5:0] shSel;
  logic              shHit;
  assign shOff = busAddr - BUS_AW'(OFS_SHADOW);
  assign shSel = shOff[BUS_AW-1:4];
  assign shHit = (busAddr >= BUS_AW'(OFS_SHADOW)) && (busAddr[3:0] == 4'd0)
                 && (int'(shSel) < NUM_WORDS);

  always_comb begin
    busRdata = '0;
    if (busAddr == BUS_AW'(OFS_CTRL) || busAddr == BUS_AW'(OFS_SET)
        || busAddr == BUS_AW'(OFS_CLR)) begin
      busRdata = {keyQ, 5'd0, strb.reloading, errQ, strb.busy, selQ};
    end else if (busAddr == BUS_AW'(OFS_TIMING)) begin
      busRdata = timingQ;
    end else if (shHit) begin
      busRdata = shadowWord[shSel[IDXW-1:0]];
    end
  end

  assign progData  = dataQ;
  assign timingCfg = timingQ;

  p_key_selfclear_r5: assert property (@(posedge clk) disable iff (!rstN)
    evt.progReq |=> (keyQ == '0));
  p_busy_cmd_err_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strb.busy && evt.progReq) |=> errQ);
  p_err_sticky_r11: assert property (@(posedge clk) disable iff (!rstN)
    (errQ && !(wrClr && busWdata[BIT_ERR])) |=> errQ);
  p_data_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    strb.busy |=> $stable(dataQ));
endmodule

// File: rtl/otp_ctl_fsm.sv
module otp_ctl_fsm
  import otp_fuse_pkg::*;
#(
  parameter int NUM_WORDS    = 32,
  parameter int QUIET_CYCLES = 200
) (
  input  logic             clk,
  input  logic             rstN,
  input  reqEvt_t          evt,
  input  logic             fuseAck,
  input  logic             fuseErr,
  output ctrlStrb_t        strb,
  output logic             fuseReq,
  output logic             fuseProg,
  output logic [SEL_W-1:0] fuseIdx
);
  localparam int QW = (QUIET_CYCLES > 1) ? $clog2(QUIET_CYCLES) : 1;

  ctlState_e        state;
  logic [SEL_W-1:0] idxQ;
  logic [QW-1:0]    quietCnt;
  logic             busy, accept, startReload, lastWord;

  assign busy        = (state != ST_IDLE);
  assign accept      = (state == ST_IDLE) && evt.progReq && evt.keyOk && evt.idxOk;
  assign startReload = (state == ST_IDLE) && evt.reloadReq;
  assign lastWord    = (idxQ == SEL_W'(NUM_WORDS - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      idxQ     <= '0;
      quietCnt <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            state <= ST_PROG;
            idxQ  <= evt.idx;
          end else if (startReload) begin
            state <= ST_RELOAD;
            idxQ  <= '0;
          end
        end
        ST_PROG: begin
          if (fuseAck) begin
            state    <= ST_QUIET;
            quietCnt <= '0;
          end
        end
        ST_QUIET: begin
          if (quietCnt == QW'(QUIET_CYCLES - 1)) state <= ST_IDLE;
          else quietCnt <= quietCnt + 1'b1;
        end
        ST_RELOAD: begin
          if (fuseAck) begin
            if (lastWord) state <= ST_IDLE;
            else idxQ <= idxQ + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign fuseReq  = (state == ST_PROG) || (state == ST_RELOAD);
  assign fuseProg = (state == ST_PROG);
  assign fuseIdx  = idxQ;

  assign strb.busy      = busy;
  assign strb.reloading = (state == ST_RELOAD);
  assign strb.setErr    = (evt.progReq && !accept) || (evt.reloadReq && busy)
                          || (fuseReq && fuseAck && fuseErr);
  assign strb.shadowWe  = (state == ST_RELOAD) && fuseAck;
  assign strb.shadowIdx = idxQ;

  p_req_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (fuseReq && !fuseAck) |=> (fuseReq && $stable(fuseIdx) && $stable(fuseProg)));
  p_no_prog_badkey_r5: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && evt.progReq && !evt.keyOk) |=> !fuseReq);
  p_quiet_len_r7: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_QUIET && quietCnt != QW'(QUIET_CYCLES - 1)) |=> strb.busy && !fuseReq);
  p_prog_then_quiet_r7: assert property (@(posedge clk) disable iff (!rstN)
    (fuseProg && fuseAck) |=> (strb.busy && !fuseReq));
  p_reload_order_r9: assert property (@(posedge clk) disable iff (!rstN)
    (strb.reloading && fuseAck && !lastWord) |=> (fuseIdx == $past(fuseIdx) + 1'b1));
endmodule

// File: rtl/otp_fuse_ctrl.sv
module otp_fuse_ctrl
  import otp_fuse_pkg::*;
#(
  parameter int NUM_WORDS    = 32,
  parameter int QUIET_CYCLES = 200,
  parameter int BUS_AW       = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWe,
  input  logic [BUS_AW-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  output logic              fuseReq,
  output logic              fuseProg,
  output logic [7:0]        fuseIdx,
  output logic [31:0]       fuseWdata,
  input  logic              fuseAck,
  input  logic              fuseErr,
  input  logic [31:0]       fuseRdata,
  output logic [31:0]       timingCfg
);
  reqEvt_t   evt;
  ctrlStrb_t strb;

  otp_reg_dp #(.NUM_WORDS(NUM_WORDS), .BUS_AW(BUS_AW)) u_dp (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .strb(strb),
    .fuseRdata(fuseRdata), .evt(evt), .progData(fuseWdata),
    .timingCfg(timingCfg)
  );

  otp_ctl_fsm #(.NUM_WORDS(NUM_WORDS), .QUIET_CYCLES(QUIET_CYCLES)) u_ctl (
    .clk(clk), .rstN(rstN), .evt(evt), .fuseAck(fuseAck), .fuseErr(fuseErr),
    .strb(strb), .fuseReq(fuseReq), .fuseProg(fuseProg), .fuseIdx(fuseIdx)
  );
endmodule

// File: tb/tb_otp_fuse_ctrl.sv
module tb_otp_fuse_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NW  = 32;
  localparam int QC  = 20;
  localparam int LAT = 3;
  localparam logic [15:0] KEY = 16'h3E77;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWe = 1'b0;
  logic [11:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        fuseReq, fuseProg;
  logic [7:0]  fuseIdx;
  logic [31:0] fuseWdata;
  logic        fuseAck = 1'b0;
  logic        fuseErr = 1'b0;
  logic [31:0] fuseRdata = '0;
  logic [31:0] timingCfg;

  otp_fuse_ctrl #(.NUM_WORDS(NW), .QUIET_CYCLES(QC), .BUS_AW(12)) dut (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .fuseReq(fuseReq),
    .fuseProg(fuseProg), .fuseIdx(fuseIdx), .fuseWdata(fuseWdata),
    .fuseAck(fuseAck), .fuseErr(fuseErr), .fuseRdata(fuseRdata),
    .timingCfg(timingCfg)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  // behavioural fuse array
  logic [31:0] arr [NW];
  int  waitCnt = 0;
  int  progCount = 0;
  int  lastProgIdx = -1;
  logic [31:0] lastProgData = '0;
  bit  failNext = 1'b0;
  int  readCount = 0;
  int  lastReadIdx = -1;
  int  orderErr = 0;

  initial for (int i = 0; i < NW; i++) arr[i] = '0;

  always @(negedge clk) begin
    if (fuseAck) begin
      fuseAck = 1'b0;
      fuseErr = 1'b0;
    end else if (rstN && fuseReq) begin
      if (waitCnt == LAT - 1) begin
        waitCnt = 0;
        fuseAck = 1'b1;
        if (fuseProg) begin
          progCount++;
          lastProgIdx  = int'(fuseIdx);
          lastProgData = fuseWdata;
          fuseErr = failNext;
          if (!failNext) arr[fuseIdx] = arr[fuseIdx] | fuseWdata;
          failNext = 1'b0;
        end else begin
          if (int'(fuseIdx) != lastReadIdx + 1) orderErr++;
          lastReadIdx = int'(fuseIdx);
          readCount++;
          fuseRdata = arr[fuseIdx];
        end
      end else begin
        waitCnt++;
      end
    end
  end

  function automatic logic [31:0] expCtrl(logic [15:0] k, logic [7:0] s,
                                          bit busy, bit err, bit rel);
    return {k, 5'd0, rel, err, busy, s};
  endfunction

  function automatic logic [11:0] shOfs(int i);
    return 12'(12'h400 + i * 16);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    busWe = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    busAddr = a;
    #1;
    d = busRdata;
  endtask

  task automatic waitIdle(output int n);
    logic [31:0] v;
    n = 0;
    rd(12'h000, v);
    while (v[8] && n < 20000) begin
      n++;
      @(negedge clk);
      rd(12'h000, v);
    end
  endtask

  logic [31:0] expArr [NW];

  initial begin
    logic [31:0] v, d;
    logic [15:0] mKey;
    logic [7:0]  mSel;
    int n, pc, rc;
    for (int i = 0; i < NW; i++) expArr[i] = '0;
    void'($urandom(32'h5EED_0017));

    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(12'h000, v); check("R1 ctrl", v, 32'h0);
    rd(12'h010, v); check("R1 timing", v, 32'h0);
    rd(shOfs(0), v); check("R1 shadow0", v, 32'h0);
    rd(shOfs(NW-1), v); check("R1 shadowLast", v, 32'h0);
    check("R1 fuseReq", {31'd0, fuseReq}, 32'h0);

    // R2 directed alias behaviour
    wr(12'h000, 32'h3E77_0005); rd(12'h000, v);
    check("R2 base", v, expCtrl(16'h3E77, 8'h05, 0, 0, 0));
    wr(12'h004, 32'h0000_0010); rd(12'h000, v);
    check("R2 set", v, expCtrl(16'h3E77, 8'h15, 0, 0, 0));
    wr(12'h008, 32'h3E00_0001); rd(12'h000, v);
    check("R2 clr", v, expCtrl(16'h0077, 8'h14, 0, 0, 0));
    mKey = 16'h0077; mSel = 8'h14;
    // R2 random alias traffic
    for (int it = 0; it < 24; it++) begin
      int op;
      op = int'($urandom % 3);
      d = $urandom & 32'hFFFF_F8FF;
      if (op == 0) begin wr(12'h000, d); mKey = d[31:16]; mSel = d[7:0]; end
      else if (op == 1) begin wr(12'h004, d); mKey |= d[31:16]; mSel |= d[7:0]; end
      else begin wr(12'h008, d); mKey &= ~d[31:16]; mSel &= ~d[7:0]; end
      rd(12'h000, v);
      check("R2 random", v, expCtrl(mKey, mSel, 0, 0, 0));
    end

    // R3 timing register
    d = $urandom;
    wr(12'h010, d); rd(12'h010, v);
    check("R3 readback", v, d);
    check("R3 port", timingCfg, d);

    // R4 / R7 program with correct key
    wr(12'h000, {KEY, 8'h00, 8'd5});
    pc = progCount;
    wr(12'h020, 32'h0000_00A5);
    rd(12'h000, v);
    check("R4 busy high", {31'd0, v[8]}, 32'd1);
    check("R5 key cleared", {16'd0, v[31:16]}, 32'h0);
    waitIdle(n);
    check("R7 busy cycles", n, LAT + QC);
    check("R4 one program", progCount - pc, 1);
    check("R4 prog idx", lastProgIdx, 5);
    check("R4 prog data", lastProgData, 32'h0000_00A5);
    expArr[5] |= 32'h0000_00A5;
    rd(shOfs(5), v);
    check("R9 shadow unchanged by program", v, 32'h0);

    // R5 wrong key
    wr(12'h000, {16'h1234, 8'h00, 8'd3});
    pc = progCount;
    wr(12'h020, 32'hFFFF_FFFF);
    @(negedge clk);
    rd(12'h000, v);
    check("R5 bad key", v, expCtrl(16'h0, 8'd3, 0, 1, 0));
    repeat (LAT + 2) @(negedge clk);
    check("R5 no program", progCount - pc, 0);

    // R11 error sticky, base write does not clear
    wr(12'h000, 32'h0000_0203); rd(12'h000, v);
    check("R11 base keeps err", {31'd0, v[9]}, 32'd1);
    wr(12'h008, 32'h0000_0200); rd(12'h000, v);
    check("R11 clr alias clears", {31'd0, v[9]}, 32'd0);

    // R6 out of range select
    wr(12'h000, {KEY, 8'h00, 8'(NW)});
    pc = progCount;
    wr(12'h020, 32'h1);
    repeat (LAT + 2) @(negedge clk);
    rd(12'h000, v);
    check("R6 err", {31'd0, v[9]}, 32'd1);
    check("R6 no program", progCount - pc, 0);
    wr(12'h008, 32'h0000_0200);

    // R8 commands while busy
    wr(12'h000, {KEY, 8'h00, 8'd7});
    pc = progCount; rc = readCount;
    wr(12'h020, 32'h0000_0F00);
    wr(12'h000, {KEY, 8'h00, 8'd8});
    wr(12'h020, 32'h0000_00FF);
    rd(12'h000, v);
    check("R8 data while busy err", {31'd0, v[9]}, 32'd1);
    wr(12'h008, 32'h0000_0200);
    wr(12'h004, 32'h0000_0400);
    rd(12'h000, v);
    check("R8 reload while busy err", {31'd0, v[9]}, 32'd1);
    waitIdle(n);
    check("R8 single program", progCount - pc, 1);
    check("R8 program kept first data", lastProgData, 32'h0000_0F00);
    check("R8 no reload", readCount - rc, 0);
    rd(12'h000, v);
    check("R8 reload bit low", {31'd0, v[10]}, 32'd0);
    expArr[7] |= 32'h0000_0F00;
    wr(12'h008, 32'h0000_0200);

    // R11 array failure
    wr(12'h000, {KEY, 8'h00, 8'd2});
    failNext = 1'b1;
    wr(12'h020, 32'hFFFF_0000);
    waitIdle(n);
    rd(12'h000, v);
    check("R11 fuseErr sets err", {31'd0, v[9]}, 32'd1);
    wr(12'h008, 32'h0000_0200);

    // R9 random programs then reload (OR accumulation in the array)
    for (int it = 0; it < 8; it++) begin
      int idx;
      idx = int'($urandom % NW);
      d = $urandom;
      wr(12'h000, {KEY, 8'h00, 8'(idx)});
      wr(12'h020, d);
      waitIdle(n);
      expArr[idx] |= d;
    end
    wr(12'h000, {KEY, 8'h00, 8'd3});
    wr(12'h020, 32'h8000_0001);
    waitIdle(n);
    expArr[3] |= 32'h8000_0001;
    wr(12'h000, {KEY, 8'h00, 8'd3});
    wr(12'h020, 32'h0000_0010);
    waitIdle(n);
    expArr[3] |= 32'h0000_0010;

    rc = readCount; lastReadIdx = -1;
    wr(12'h004, 32'h0000_0400);
    rd(12'h000, v);
    check("R9 reload bit", {30'd0, v[10], v[8]}, 32'd3);
    waitIdle(n);
    check("R9 word count", readCount - rc, NW);
    check("R9 ascending order", orderErr, 0);
    for (int i = 0; i < NW; i++) begin
      rd(shOfs(i), v);
      check($sformatf("R9 shadow %0d", i), v, expArr[i]);
    end

    // R9 reload via base address
    wr(12'h000, {KEY, 8'h00, 8'd9});
    wr(12'h020, 32'h0000_C000);
    waitIdle(n);
    expArr[9] |= 32'h0000_C000;
    rc = readCount; lastReadIdx = -1;
    wr(12'h000, 32'h0000_0400);
    waitIdle(n);
    check("R9 base reload count", readCount - rc, NW);
    rd(shOfs(9), v); check("R9 base reload word", v, expArr[9]);

    // R10 window decode
    rd(shOfs(NW), v); check("R10 beyond last", v, 32'h0);
    rd(12'h404, v); check("R10 unaligned", v, 32'h0);
    rd(shOfs(NW-1), v); check("R10 last word", v, expArr[NW-1]);

    finished = 1'b1;
    $display("  End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end
endmodule